// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact floating-point word. The default word is 20 bits wide: one sign bit, a 7-bit biased exponent and a 12-bit fraction with an implied leading one. The unit is split into three register stages. The first compares the two magnitudes, routes the larger one to a fixed lane and shifts the smaller significand right into alignment. The second runs one ripple kernel whose bit cell either adds or borrow-subtracts. The third renormalizes the raw result and packs it back into a word.

The kernel always sees the larger magnitude first, so its result can never go negative. No complement stage and no second adder are needed. The sign of the result comes from the operand that won the magnitude comparison. A new operation can be issued on every clock. A result arrives three clocks after its operands are sampled.

Top module: `fpas_addsub`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge sets `out_valid` high, with its result on `result`, right after the third rising edge counted from that one. A cycle without `in_valid` gives a cycle with `out_valid` low three edges later. Back-to-back operations are accepted on every clock.
- R2: Word layout: the MSB is the sign. The next EXP_W bits are the exponent, with bias 2^(EXP_W-1)-1. The low MAN_W bits are the fraction of the significand 1.f. An exponent field of 0 means the value is zero, whatever the fraction bits hold. Such an operand contributes a significand of 0, and a zero operand leaves the other operand unchanged. `op_sub`=1 selects a-b and `op_sub`=0 selects a+b.
- R3: When the effective operation is an addition, the significands are added after the smaller one has been aligned. The effective operation is the requested one XORed with the sign difference. Alignment is a right shift by the exponent difference, and the bits shifted out are dropped (truncation).
- R4: When the effective operation is a subtraction, the result magnitude is the larger significand minus the aligned smaller one. The result sign is that of the larger-magnitude operand, taking operand b as negated when `op_sub`=1. On equal magnitudes no swap occurs and a's sign is used.
- R5: When the exponent difference exceeds MAN_W, the smaller operand contributes nothing and the result equals the larger operand with the sign rule of R4.
- R6: A carry out of the kernel shifts the result right by one bit, dropping its LSB, and increments the exponent.
- R7: Leading zeros in the kernel result are removed by a left shift, and the exponent is lowered by the shift count. If the exponent would reach 0 or less, the result is flushed to the all-zero word.
- R8: An exact-zero result is the all-zero word (positive sign, exponent 0, fraction 0).
- R9: When normalization would produce an exponent of 2^EXP_W-1 or above, the result saturates to infinity: the result sign, an all-ones exponent and a zero fraction.
- R10: `result` keeps its value in every cycle where `out_valid` is low.
- R11: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 1 selects a-b, 0 selects a+b |
| opnd_a | input | 1+EXP_W+MAN_W | First operand |
| opnd_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | `result` carries a new value |
| result | output | 1+EXP_W+MAN_W | Sum or difference |

## Verification
The bench uses a 3-bit exponent and a 3-bit fraction and sweeps every operand pair with both operations, one operation per clock. Pairs with an all-ones exponent are left out, and they form natural bubbles in the stream. Same-sign additions separate correct alignment truncation and carry handling (R3, R6, R9). Mixed-sign and subtract cases separate the swap and sign choice and the borrow mode of the shared cell (R4), and the near-equal pairs among them expose the leading-zero shift, cancellation to zero and underflow flushing (R7, R8). Zero operands and large exponent gaps show that zeros pass through and that far-shifted operands vanish (R2, R5). The bubbles show whether valid timing and output holding are right (R1, R10).

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic {
    FPAS_ADD = 1'b0,
    FPAS_SUB = 1'b1
  } fpas_op_e;
endpackage

// File: rtl/fpas_align.sv
// Stage 1: magnitude compare, operand swap, right alignment of the smaller significand.
module fpas_align #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   op_sub,
  input  logic [EXP_W+MAN_W:0]   opnd_a,
  input  logic [EXP_W+MAN_W:0]   opnd_b,
  output logic                   s1_valid,
  output logic                   s1_sub,
  output logic                   s1_sign,
  output logic [EXP_W-1:0]       s1_exp,
  output logic [MAN_W:0]         s1_big,
  output logic [MAN_W:0]         s1_small
);
  import fpas_pkg::*;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;

  fpas_op_e             op;
  logic                 sign_a, sign_b_eff, swap;
  logic [EXP_W-1:0]     exp_a, exp_b, exp_big, exp_sml, shamt;
  logic [MAN_W-1:0]     man_big, man_sml;
  logic [SIG_W-1:0]     sig_sml;
  logic                 nxt_sub, nxt_sign;
  logic [SIG_W-1:0]     nxt_big, nxt_small;

  always_comb begin
    op         = fpas_op_e'(op_sub);
    sign_a     = opnd_a[W-1];
    sign_b_eff = opnd_b[W-1] ^ (op == FPAS_SUB);
    exp_a      = opnd_a[W-2 -: EXP_W];
    exp_b      = opnd_b[W-2 -: EXP_W];
    swap       = opnd_b[W-2:0] > opnd_a[W-2:0];
    exp_big    = swap ? exp_b : exp_a;
    exp_sml    = swap ? exp_a : exp_b;
    man_big    = swap ? opnd_b[MAN_W-1:0] : opnd_a[MAN_W-1:0];
    man_sml    = swap ? opnd_a[MAN_W-1:0] : opnd_b[MAN_W-1:0];
    nxt_big    = (exp_big != '0) ? {1'b1, man_big} : '0;
    sig_sml    = (exp_sml != '0) ? {1'b1, man_sml} : '0;
    shamt      = exp_big - exp_sml;
    nxt_small  = sig_sml >> shamt;
    nxt_sign   = swap ? sign_b_eff : sign_a;
    nxt_sub    = sign_a ^ sign_b_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sub   <= 1'b0;
      s1_sign  <= 1'b0;
      s1_exp   <= '0;
      s1_big   <= '0;
      s1_small <= '0;
    end else if (in_valid) begin
      s1_sub   <= nxt_sub;
      s1_sign  <= nxt_sign;
      s1_exp   <= exp_big;
      s1_big   <= nxt_big;
      s1_small <= nxt_small;
    end
  end
endmodule

// File: rtl/fpas_kernel.sv
// Stage 2: one ripple chain of shared add/borrow-subtract bit cells.
module fpas_kernel #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic               s1_sub,
  input  logic               s1_sign,
  input  logic [EXP_W-1:0]   s1_exp,
  input  logic [MAN_W:0]     s1_big,
  input  logic [MAN_W:0]     s1_small,
  output logic               s2_valid,
  output logic               s2_sign,
  output logic [EXP_W-1:0]   s2_exp,
  output logic [MAN_W+1:0]   s2_raw
);
  localparam int SIG_W = MAN_W + 1;

  logic [SIG_W:0]   chain;
  logic [SIG_W-1:0] sum_w;
  logic [SIG_W:0]   nxt_raw;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < SIG_W; i++) begin : g_cell
    // Same sum equation in both modes; carry vs. borrow differ only by inverting x.
    assign sum_w[i]   = s1_big[i] ^ s1_small[i] ^ chain[i];
    assign chain[i+1] = ((s1_big[i] ^ s1_sub) & (s1_small[i] | chain[i]))
                      | (s1_small[i] & chain[i]);
  end

  always_comb begin
    nxt_raw = {chain[SIG_W] & ~s1_sub, sum_w};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_sign <= 1'b0;
      s2_exp  <= '0;
      s2_raw  <= '0;
    end else if (s1_valid) begin
      s2_sign <= s1_sign;
      s2_exp  <= s1_exp;
      s2_raw  <= nxt_raw;
    end
  end
endmodule

// File: rtl/fpas_norm.sv
// Stage 3: renormalization, zero / flush / saturation encoding.
module fpas_norm #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s2_valid,
  input  logic                 s2_sign,
  input  logic [EXP_W-1:0]     s2_exp,
  input  logic [MAN_W+1:0]     s2_raw,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] result
);
  localparam int W        = 1 + EXP_W + MAN_W;
  localparam int SIG_W    = MAN_W + 1;
  localparam int LZ_W     = $clog2(SIG_W + 1);
  localparam int EXP_ONES = (1 << EXP_W) - 1;

  logic [LZ_W-1:0] lz;
  logic [MAN_W:0]  shl;
  logic [W-1:0]    nxt_res;
  int              e_inc, e_dec;

  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (s2_raw[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
    shl   = s2_raw[MAN_W:0] << lz;
    e_inc = int'(s2_exp) + 1;
    e_dec = int'(s2_exp) - int'(lz);
    if (s2_raw == '0) begin
      nxt_res = '0;
    end else if (s2_raw[SIG_W]) begin
      if (e_inc >= EXP_ONES) nxt_res = {s2_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else                   nxt_res = {s2_sign, EXP_W'(e_inc), s2_raw[MAN_W:1]};
    end else if (e_dec <= 0) begin
      nxt_res = '0;
    end else begin
      nxt_res = {s2_sign, EXP_W'(e_dec), shl[MAN_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= '0;
    else if (s2_valid) result <= nxt_res;
  end
endmodule

// File: rtl/fpas_addsub.sv
module fpas_addsub #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 op_sub,
  input  logic [EXP_W+MAN_W:0] opnd_a,
  input  logic [EXP_W+MAN_W:0] opnd_b,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] result
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             s1_valid, s1_sub, s1_sign;
  logic [EXP_W-1:0] s1_exp;
  logic [MAN_W:0]   s1_big, s1_small;
  logic             s2_valid, s2_sign;
  logic [EXP_W-1:0] s2_exp;
  logic [MAN_W+1:0] s2_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .s1_valid(s1_valid), .s1_sub(s1_sub),
    .s1_sign(s1_sign), .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small)
  );

  fpas_kernel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_kernel (
    .clk(clk), .rst_n(rst_int_n), .s1_valid(s1_valid), .s1_sub(s1_sub),
    .s1_sign(s1_sign), .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_raw(s2_raw)
  );

  fpas_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst_n(rst_int_n), .s2_valid(s2_valid), .s2_sign(s2_sign),
    .s2_exp(s2_exp), .s2_raw(s2_raw), .out_valid(out_valid), .result(result)
  );
endmodule

// File: rtl/fpas_addsub_chk.sv
module fpas_addsub_chk #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 s1_valid,
  input logic                 s1_sub,
  input logic [MAN_W:0]       s1_big,
  input logic [MAN_W:0]       s1_small,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] result
);
  localparam int W = 1 + EXP_W + MAN_W;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);                                              // R1
  AST_BUBBLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);                                            // R1
  AST_KERNEL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_sub) |-> (s1_big >= s1_small));                           // R4
  AST_ZERO_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[W-2 -: EXP_W] == '0) |-> (result == '0));            // R8
  AST_INF_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&result[W-2 -: EXP_W])) |-> (result[MAN_W-1:0] == '0));    // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));                                          // R10
endmodule

bind fpas_addsub fpas_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .s1_valid(s1_valid),
  .s1_sub(s1_sub), .s1_big(s1_big), .s1_small(s1_small),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_fpas_addsub.sv
module tb_fpas_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int E = 3;
  localparam int M = 3;
  localparam int W = 1 + E + M;
  localparam int NOPS = 1 << (2 * W + 1);

  logic         clk, rst_n, in_valid, op_sub, out_valid;
  logic [W-1:0] opnd_a, opnd_b, result;

  int n_chk = 0;
  int n_fail = 0;

  fpas_addsub #(.EXP_W(E), .MAN_W(M)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic sub, output logic [W-1:0] r,
                                output string tag);
    int ea, eb, ma, mb, sa, sbe, eB, eS, sgB, sgS, sB, d, al, raw, e, p, lz, v;
    int mask;
    mask = (1 << M) - 1;
    ea = int'(a[W-2:M]); eb = int'(b[W-2:M]);
    ma = int'(a[M-1:0]); mb = int'(b[M-1:0]);
    sa = int'(a[W-1]);   sbe = int'(b[W-1] ^ sub);
    if ((eb * (1 << M) + mb) > (ea * (1 << M) + ma)) begin
      eB = eb; sgB = (eb != 0) ? ((1 << M) + mb) : 0; sB = sbe;
      eS = ea; sgS = (ea != 0) ? ((1 << M) + ma) : 0;
    end else begin
      eB = ea; sgB = (ea != 0) ? ((1 << M) + ma) : 0; sB = sa;
      eS = eb; sgS = (eb != 0) ? ((1 << M) + mb) : 0;
    end
    d   = eB - eS;
    al  = sgS >> d;
    raw = (sa != sbe) ? (sgB - al) : (sgB + al);
    tag = (sa != sbe) ? "R4" : "R3";
    if (d > M && sgS != 0) tag = "R5";
    if (ea == 0 || eb == 0) tag = "R2";
    v = 0;
    if (raw == 0) begin
      tag = "R8";
    end else if (raw >= (1 << (M + 1))) begin
      tag = "R6";
      e = eB + 1;
      if (e >= (1 << E) - 1) begin
        tag = "R9";
        v = (sB << (W - 1)) | (((1 << E) - 1) << M);
      end else begin
        v = (sB << (W - 1)) | (e << M) | ((raw >> 1) & mask);
      end
    end else begin
      p = 0;
      for (int i = 0; i <= M; i++) if (((raw >> i) & 1) == 1) p = i;
      lz = M - p;
      e  = eB - lz;
      if (e <= 0) tag = "R7";
      else v = (sB << (W - 1)) | (e << M) | ((raw << lz) & mask);
    end
    r = W'(v);
  endfunction

  logic         h_vld [4];
  logic [W-1:0] h_exp [4];
  logic [W-1:0] h_a [4];
  logic [W-1:0] h_b [4];
  logic         h_sub [4];
  string        h_tag [4];

  initial begin
    logic [2*W:0] idx;
    logic [W-1:0] prev_res;
    int           s;
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R11 reset: out_valid=%b result=%h expected 0/0", out_valid, result);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prev_res = result;
    for (int t = 0; t < NOPS + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        s = (t - 3) % 4;
        n_chk++;
        if (out_valid !== h_vld[s]) begin
          n_fail++;
          $display("FAIL R1 valid timing op %0d: got %b expected %b", t - 3, out_valid, h_vld[s]);
        end
        n_chk++;
        if (h_vld[s]) begin
          if (result !== h_exp[s]) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h sub=%b: got %h expected %h",
                     h_tag[s], h_a[s], h_b[s], h_sub[s], result, h_exp[s]);
          end
        end else if (result !== prev_res) begin
          n_fail++;
          $display("FAIL R10 hold: got %h expected %h", result, prev_res);
        end
      end
      prev_res = result;
      s = t % 4;
      if (t < NOPS) begin
        idx      = (2 * W + 1)'(t);
        opnd_a   = idx[W-1:0];
        opnd_b   = idx[2*W-1:W];
        op_sub   = idx[2*W];
        in_valid = !(&opnd_a[W-2:M]) && !(&opnd_b[W-2:M]);
      end else begin
        in_valid = 1'b0;
      end
      h_vld[s] = in_valid;
      h_a[s]   = opnd_a;
      h_b[s]   = opnd_b;
      h_sub[s] = op_sub;
      if (in_valid) model(opnd_a, opnd_b, op_sub, h_exp[s], h_tag[s]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule